// File: doc/BRIEF.md
# Operand-Snooping Reservation Station Cluster

This block is the scheduling core of an out-of-order integer execution cluster. It holds five reservation stations. Three feed a two-cycle add/subtract unit and two feed a three-cycle multiply unit. Neither unit is pipelined. The front end hands over one operation per cycle. Each source comes either as a ready value (tag 0) or as the nonzero tag of the station that will produce it. The block gives back the tag of the station it allocated, and that tag becomes the rename name of the result. No register number is kept inside the cluster, so a later write to a source register cannot disturb an operation that is waiting.

Every station watches a single shared result bus. A station whose operand tag matches the tag on the bus copies the value and clears the tag. A station whose tags are both clear is started on its unit once that unit is idle. When the unit finishes, it places the station tag and the result on the bus for one cycle, and the station is released. When both units finish in the same cycle, the multiply unit takes the bus and the adder holds its result. An operation issued in the same cycle as a broadcast it depends on picks up the value directly from the bus.

Top module: `rs_cluster`

## Requirements
- R1: After reset every station is free. `bus_valid` is 0, `iss_ready` is 1 for each legal operation code, and `iss_tag` is 1 for codes 0 and 1 and 4 for code 2.
- R2: Operation codes are 0 add, 1 subtract, 2 multiply and 3 illegal. Codes 0 and 1 take the lowest free station among tags 1..3, and code 2 takes the lowest free station among tags 4..5. This tag is shown on `iss_tag`. Code 3 never sees `iss_ready` high.
- R3: `iss_ready` is low while every station of the required unit is occupied, and the operation presented is then not taken.
- R4: A source with tag 0 uses the value given at issue. A source with a nonzero tag waits, then captures `bus_value` in the cycle `bus_tag` equals that tag.
- R5: If a source tag matches the tag broadcast in the very cycle of issue, that broadcast value is used.
- R6: A station starts only when both source tags are clear and its unit is idle. Among several ready stations of one unit, the lowest tag starts first.
- R7: An add or subtract issued with both sources ready in cycle N broadcasts in cycle N+3 if uncontended. A multiply issued the same way broadcasts in cycle N+4.
- R8: Each unit runs one operation at a time. A second ready station of the same unit starts only after the first result has been broadcast.
- R9: Results are a+b, a−b and the low DATA_W bits of a×b, all modulo 2^DATA_W.
- R10: Only one unit drives the bus per cycle. On a tie the multiply result goes out and the add result goes out in the next cycle.
- R11: Each accepted operation is broadcast exactly once. Its station becomes allocatable again in the cycle after the broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An operation is presented for issue |
| iss_op | input | 2 | Operation code (0 add, 1 sub, 2 mul, 3 illegal) |
| iss_vj | input | DATA_W | First source value, used when iss_qj is 0 |
| iss_qj | input | TAG_W | First source producer tag, 0 when value is ready |
| iss_vk | input | DATA_W | Second source value, used when iss_qk is 0 |
| iss_qk | input | TAG_W | Second source producer tag, 0 when value is ready |
| iss_ready | output | 1 | A station of the required unit is free |
| iss_tag | output | TAG_W | Tag of the station that takes the operation |
| bus_valid | output | 1 | Result bus carries a broadcast this cycle |
| bus_tag | output | TAG_W | Tag of the broadcasting station |
| bus_value | output | DATA_W | Broadcast result |

## Verification
Isolated single operations, each separated by idle gaps, pin down the bare latency of each unit and the arithmetic, including subtract wraparound and multiply truncation. A dependent add timed to issue exactly when its producer broadcasts separates the issue-time bypass from the ordinary snoop path. A multiply and an add arranged to finish together expose the bus priority and the one-cycle hold. Three adds waiting on one producer, followed by a fourth add, separate the lowest-first start order and the full-pool stall. A long stream of random dependent operations with random gaps is then compared cycle by cycle against a behavioural model. That stream mixes every ordering of snoops, stalls and collisions.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_MUL  = 2'd2,
        OP_NONE = 2'd3
    } rs_op_e;
endpackage

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 3,
    parameter int MY_TAG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  rs_op_e            iss_op_i,
    input  logic [DATA_W-1:0] iss_vj_i,
    input  logic [TAG_W-1:0]  iss_qj_i,
    input  logic [DATA_W-1:0] iss_vk_i,
    input  logic [TAG_W-1:0]  iss_qk_i,
    input  logic              bus_valid_i,
    input  logic [TAG_W-1:0]  bus_tag_i,
    input  logic [DATA_W-1:0] bus_value_i,
    input  logic              dispatch_i,
    output logic              busy_o,
    output logic              ready_o,
    output rs_op_e            op_o,
    output logic [DATA_W-1:0] vj_o,
    output logic [DATA_W-1:0] vk_o
);
    localparam logic [TAG_W-1:0] SELF = TAG_W'(MY_TAG);

    typedef struct packed {
        logic              busy;
        logic              run;
        rs_op_e            op;
        logic [DATA_W-1:0] vj;
        logic [DATA_W-1:0] vk;
        logic [TAG_W-1:0]  qj;
        logic [TAG_W-1:0]  qk;
    } slot_t;

    slot_t slot_d, slot_q;

    // Tag hit on the shared bus for a pending operand (tag 0 never matches).
    function automatic logic hit(input logic [TAG_W-1:0] q, input logic v,
                                 input logic [TAG_W-1:0] t);
        return v && (q != '0) && (q == t);
    endfunction

    always_comb begin
        slot_d = slot_q;
        if (alloc_i) begin
            slot_d.busy = 1'b1;
            slot_d.run  = 1'b0;
            slot_d.op   = iss_op_i;
            if (hit(iss_qj_i, bus_valid_i, bus_tag_i)) begin
                slot_d.vj = bus_value_i;
                slot_d.qj = '0;
            end else begin
                slot_d.vj = iss_vj_i;
                slot_d.qj = iss_qj_i;
            end
            if (hit(iss_qk_i, bus_valid_i, bus_tag_i)) begin
                slot_d.vk = bus_value_i;
                slot_d.qk = '0;
            end else begin
                slot_d.vk = iss_vk_i;
                slot_d.qk = iss_qk_i;
            end
        end else if (slot_q.busy) begin
            if (dispatch_i) begin
                slot_d.run = 1'b1;
            end
            if (hit(slot_q.qj, bus_valid_i, bus_tag_i)) begin
                slot_d.vj = bus_value_i;
                slot_d.qj = '0;
            end
            if (hit(slot_q.qk, bus_valid_i, bus_tag_i)) begin
                slot_d.vk = bus_value_i;
                slot_d.qk = '0;
            end
            if (bus_valid_i && bus_tag_i == SELF) begin
                slot_d.busy = 1'b0;
                slot_d.run  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign busy_o  = slot_q.busy;
    assign ready_o = slot_q.busy && !slot_q.run && (slot_q.qj == '0) && (slot_q.qk == '0);
    assign op_o    = slot_q.op;
    assign vj_o    = slot_q.vj;
    assign vk_o    = slot_q.vk;
endmodule

// File: rtl/rs_unit.sv
module rs_unit
    import rs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 3,
    parameter int LAT    = 2,
    parameter bit IS_MUL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  rs_op_e            op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              grant_i,
    output logic              idle_o,
    output logic              req_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] res_o
);
    localparam int CNT_W = $clog2(LAT + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] res;
        logic [TAG_W-1:0]  tag;
    } exe_t;

    exe_t exe_d, exe_q;
    logic [DATA_W-1:0] result_w;

    generate
        if (IS_MUL) begin : g_mul
            logic [DATA_W-1:0] prod_lo;
            logic [DATA_W-1:0] unused_prod_hi;
            rs_op_e            unused_op;
            assign {unused_prod_hi, prod_lo} = {{DATA_W{1'b0}}, a_i} * {{DATA_W{1'b0}}, b_i};
            assign unused_op = op_i;
            assign result_w  = prod_lo;
        end else begin : g_add
            assign result_w = (op_i == OP_SUB) ? (a_i - b_i) : (a_i + b_i);
        end
    endgenerate

    always_comb begin
        exe_d = exe_q;
        if (start_i) begin
            exe_d.cnt = CNT_W'(LAT);
            exe_d.res = result_w;
            exe_d.tag = tag_i;
        end else if (exe_q.cnt > CNT_W'(1)) begin
            exe_d.cnt = exe_q.cnt - CNT_W'(1);
        end else if (exe_q.cnt == CNT_W'(1) && grant_i) begin
            exe_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exe_q <= '0;
        end else begin
            exe_q <= exe_d;
        end
    end

    assign idle_o = (exe_q.cnt == '0);
    assign req_o  = (exe_q.cnt == CNT_W'(1));
    assign tag_o  = exe_q.tag;
    assign res_o  = exe_q.res;
endmodule

// File: rtl/rs_cluster.sv
module rs_cluster
    import rs_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int N_ADD   = 3,
    parameter int N_MUL   = 2,
    parameter int ADD_LAT = 2,
    parameter int MUL_LAT = 3,
    localparam int N_ST   = N_ADD + N_MUL,
    localparam int TAG_W  = $clog2(N_ST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [1:0]        iss_op,
    input  logic [DATA_W-1:0] iss_vj,
    input  logic [TAG_W-1:0]  iss_qj,
    input  logic [DATA_W-1:0] iss_vk,
    input  logic [TAG_W-1:0]  iss_qk,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    output logic              bus_valid,
    output logic [TAG_W-1:0]  bus_tag,
    output logic [DATA_W-1:0] bus_value
);
    localparam int IDX_W = $clog2(N_ST);

    rs_op_e            op_in;
    logic              iss_is_mul;
    logic              iss_legal;
    logic [N_ST-1:0]   st_busy;
    logic [N_ST-1:0]   st_ready;
    logic [N_ST-1:0]   alloc_v;
    logic [N_ST-1:0]   dispatch_v;
    rs_op_e            st_op [N_ST];
    logic [DATA_W-1:0] st_vj [N_ST];
    logic [DATA_W-1:0] st_vk [N_ST];

    logic              alloc_hit;
    logic [IDX_W-1:0]  alloc_pick;
    logic              add_hit, mul_hit;
    logic [IDX_W-1:0]  add_sel, mul_sel;

    logic              add_start, add_idle, add_req, add_grant;
    logic              mul_start, mul_idle, mul_req, mul_grant;
    logic [TAG_W-1:0]  add_tag, mul_tag;
    logic [DATA_W-1:0] add_res, mul_res;

    assign op_in      = rs_op_e'(iss_op);
    assign iss_is_mul = (op_in == OP_MUL);
    assign iss_legal  = (op_in != OP_NONE);

    // Lowest free station inside the range owned by the requested unit.
    always_comb begin : alloc_search
        alloc_hit  = 1'b0;
        alloc_pick = '0;
        for (int i = 0; i < N_ST; i++) begin
            if (!alloc_hit && !st_busy[i] &&
                ((iss_is_mul && i >= N_ADD) || (!iss_is_mul && i < N_ADD))) begin
                alloc_hit  = 1'b1;
                alloc_pick = IDX_W'(i);
            end
        end
    end

    assign iss_ready = iss_legal && alloc_hit;
    assign iss_tag   = TAG_W'(alloc_pick) + TAG_W'(1);

    // Fixed low-index priority among ready stations of each unit.
    always_comb begin : add_search
        add_hit = 1'b0;
        add_sel = '0;
        for (int i = 0; i < N_ADD; i++) begin
            if (!add_hit && st_ready[i]) begin
                add_hit = 1'b1;
                add_sel = IDX_W'(i);
            end
        end
    end

    always_comb begin : mul_search
        mul_hit = 1'b0;
        mul_sel = IDX_W'(N_ADD);
        for (int i = N_ADD; i < N_ST; i++) begin
            if (!mul_hit && st_ready[i]) begin
                mul_hit = 1'b1;
                mul_sel = IDX_W'(i);
            end
        end
    end

    assign add_start = add_idle && add_hit;
    assign mul_start = mul_idle && mul_hit;

    // Single result bus: multiplier wins a tie, adder waits.
    assign mul_grant = mul_req;
    assign add_grant = add_req && !mul_req;
    assign bus_valid = add_req || mul_req;
    assign bus_tag   = mul_req ? mul_tag : add_tag;
    assign bus_value = mul_req ? mul_res : add_res;

    generate
        for (genvar g = 0; g < N_ST; g++) begin : g_st
            assign alloc_v[g]    = iss_valid && iss_ready && (alloc_pick == IDX_W'(g));
            assign dispatch_v[g] = (add_start && add_sel == IDX_W'(g)) ||
                                   (mul_start && mul_sel == IDX_W'(g));
            rs_station #(
                .DATA_W (DATA_W),
                .TAG_W  (TAG_W),
                .MY_TAG (g + 1)
            ) u_st (
                .clk         (clk),
                .rst_n       (rst_n),
                .alloc_i     (alloc_v[g]),
                .iss_op_i    (op_in),
                .iss_vj_i    (iss_vj),
                .iss_qj_i    (iss_qj),
                .iss_vk_i    (iss_vk),
                .iss_qk_i    (iss_qk),
                .bus_valid_i (bus_valid),
                .bus_tag_i   (bus_tag),
                .bus_value_i (bus_value),
                .dispatch_i  (dispatch_v[g]),
                .busy_o      (st_busy[g]),
                .ready_o     (st_ready[g]),
                .op_o        (st_op[g]),
                .vj_o        (st_vj[g]),
                .vk_o        (st_vk[g])
            );
        end
    endgenerate

    rs_unit #(
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W),
        .LAT    (ADD_LAT),
        .IS_MUL (1'b0)
    ) u_add (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (add_start),
        .op_i    (st_op[add_sel]),
        .a_i     (st_vj[add_sel]),
        .b_i     (st_vk[add_sel]),
        .tag_i   (TAG_W'(add_sel) + TAG_W'(1)),
        .grant_i (add_grant),
        .idle_o  (add_idle),
        .req_o   (add_req),
        .tag_o   (add_tag),
        .res_o   (add_res)
    );

    rs_unit #(
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W),
        .LAT    (MUL_LAT),
        .IS_MUL (1'b1)
    ) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (mul_start),
        .op_i    (st_op[mul_sel]),
        .a_i     (st_vj[mul_sel]),
        .b_i     (st_vk[mul_sel]),
        .tag_i   (TAG_W'(mul_sel) + TAG_W'(1)),
        .grant_i (mul_grant),
        .idle_o  (mul_idle),
        .req_o   (mul_req),
        .tag_o   (mul_tag),
        .res_o   (mul_res)
    );
endmodule

// File: rtl/rs_cluster_chk.sv
module rs_cluster_chk #(
    parameter int N_ADD = 3,
    parameter int N_MUL = 2,
    parameter int TAG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       iss_op,
    input logic             iss_ready,
    input logic             bus_valid,
    input logic [TAG_W-1:0] bus_tag,
    input logic             add_req,
    input logic             mul_req,
    input logic             add_start,
    input logic             add_idle,
    input logic             mul_start,
    input logic             mul_idle
);
    // R2: illegal code is never accepted
    a_r2_illegal_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_op == 2'd3) |-> !iss_ready);

    // R2: broadcast tags name a real station
    a_r2_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_tag != '0) && (int'(bus_tag) <= N_ADD + N_MUL));

    // R10: multiply result owns the bus whenever it is ready
    a_r10_mul_first: assert property (@(posedge clk) disable iff (!rst_n)
        mul_req |-> bus_valid && (int'(bus_tag) > N_ADD));

    // R10: a losing add result is still pending next cycle
    a_r10_add_held: assert property (@(posedge clk) disable iff (!rst_n)
        (add_req && mul_req) |=> add_req);

    // R11: no tag is broadcast twice in a row
    a_r11_single_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> !(bus_valid && bus_tag == $past(bus_tag)));

    // R8: units only accept work when idle
    a_r8_add_not_pipelined: assert property (@(posedge clk) disable iff (!rst_n)
        add_start |-> add_idle);
    a_r8_mul_not_pipelined: assert property (@(posedge clk) disable iff (!rst_n)
        mul_start |-> mul_idle);
endmodule

bind rs_cluster rs_cluster_chk #(
    .N_ADD (N_ADD),
    .N_MUL (N_MUL),
    .TAG_W (TAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_op    (iss_op),
    .iss_ready (iss_ready),
    .bus_valid (bus_valid),
    .bus_tag   (bus_tag),
    .add_req   (add_req),
    .mul_req   (mul_req),
    .add_start (add_start),
    .add_idle  (add_idle),
    .mul_start (mul_start),
    .mul_idle  (mul_idle)
);

// File: tb/sim_rs_cluster.sv
module sim_rs_cluster;
    localparam int DW = 16;
    localparam int TW = 3;
    localparam int ALAT = 2;
    localparam int MLAT = 3;
    localparam int MAXP = 256;

    logic          clk, rst_n;
    logic          iss_valid;
    logic [1:0]    iss_op;
    logic [DW-1:0] iss_vj, iss_vk;
    logic [TW-1:0] iss_qj, iss_qk;
    logic          iss_ready;
    logic [TW-1:0] iss_tag;
    logic          bus_valid;
    logic [TW-1:0] bus_tag;
    logic [DW-1:0] bus_value;

    rs_cluster u0 (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_vj(iss_vj), .iss_qj(iss_qj), .iss_vk(iss_vk), .iss_qk(iss_qk),
        .iss_ready(iss_ready), .iss_tag(iss_tag), .bus_valid(bus_valid),
        .bus_tag(bus_tag), .bus_value(bus_value)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // program
    int            np;
    int            p_op [MAXP];
    int            p_ja [MAXP];
    int            p_ka [MAXP];
    int            p_dly[MAXP];
    int            p_tag[MAXP];
    bit            p_done[MAXP];
    logic [DW-1:0] p_jv [MAXP];
    logic [DW-1:0] p_kv [MAXP];
    logic [DW-1:0] gold [MAXP];
    logic [DW-1:0] p_res[MAXP];

    // behavioural model
    int            m_busy[6], m_run[6], m_op[6], m_qj[6], m_qk[6], m_prog[6];
    logic [DW-1:0] m_vj[6], m_vk[6];
    int            u_cnt[2], u_tag[2];
    logic [DW-1:0] u_val[2];

    int n_chk, n_bad;

    function automatic logic [DW-1:0] alu(int op, logic [DW-1:0] a, logic [DW-1:0] b);
        logic [2*DW-1:0] p;
        p = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
        case (op)
            0: return a + b;
            1: return a - b;
            2: return p[DW-1:0];
            default: return '0;
        endcase
    endfunction

    task automatic push(int op, int ja, int jv, int ka, int kv, int dly);
        logic [DW-1:0] a, b;
        p_op[np] = op; p_ja[np] = ja; p_ka[np] = ka; p_dly[np] = dly;
        p_jv[np] = DW'(jv); p_kv[np] = DW'(kv); p_done[np] = 1'b0;
        a = (ja >= 0) ? gold[ja] : DW'(jv);
        b = (ka >= 0) ? gold[ka] : DW'(kv);
        gold[np] = alu(op, a, b);
        np++;
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        int ptr, waited, done_cnt, need, cyc;
        n_chk = 0; n_bad = 0; np = 0;
        for (int s = 0; s < 6; s++) begin
            m_busy[s] = 0; m_run[s] = 0; m_op[s] = 0; m_qj[s] = 0; m_qk[s] = 0;
            m_prog[s] = 0; m_vj[s] = '0; m_vk[s] = '0;
        end
        for (int u = 0; u < 2; u++) begin u_cnt[u] = 0; u_tag[u] = 0; u_val[u] = '0; end

        // directed program
        push(0, -1, 5, -1, 7, 0);          // 0 R7 lone add
        push(1, -1, 3, -1, 10, 6);         // 1 R9 sub wrap
        push(2, -1, 300, -1, 300, 6);      // 2 R9 mul truncation
        push(2, -1, 7, -1, 6, 6);          // 3 producer
        push(0, 3, 0, -1, 1, 3);           // 4 R5 issues in broadcast cycle
        push(2, -1, 2, -1, 3, 6);          // 5 producer
        push(0, 5, 0, 5, 0, 0);            // 6 R4 both operands snooped
        push(2, -1, 4, -1, 4, 6);          // 7 R10 tie
        push(0, -1, 1, -1, 1, 0);          // 8 R10 tie
        push(2, -1, 9, -1, 9, 6);          // 9 long producer
        push(0, 9, 0, -1, 1, 0);           // 10 R6 ordering
        push(1, 9, 0, -1, 2, 0);           // 11
        push(0, 9, 0, -1, 3, 0);           // 12
        push(0, -1, 1, -1, 2, 0);          // 13 R3 add pool full
        push(2, -1, 2, -1, 2, 0);          // 14
        push(2, -1, 3, -1, 3, 0);          // 15
        push(2, -1, 4, -1, 4, 0);          // 16 R3 mul pool full
        push(3, -1, 1, -1, 1, 2);          // 17 R2 illegal code
        for (int i = 0; i < 140; i++) begin
            int ja, ka, base;
            base = np;
            ja = -1; ka = -1;
            if (base > 18 && ($urandom % 2) == 1) ja = base - 1 - int'($urandom % 4);
            if (base > 18 && ($urandom % 3) == 1) ka = base - 1 - int'($urandom % 4);
            if (ja < 18) ja = -1;
            if (ka < 18) ka = -1;
            push(int'($urandom % 3), ja, int'($urandom % 65536), ka,
                 int'($urandom % 65536), int'($urandom % 3));
        end
        need = np - 1;

        rst_n = 1'b0; iss_valid = 1'b0; iss_op = 2'd0;
        iss_vj = '0; iss_vk = '0; iss_qj = '0; iss_qk = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        iss_op = 2'd2;
        #1;
        check(bus_valid == 1'b0, "R1", "bus_valid after reset", int'(bus_valid), 0);
        check(iss_ready == 1'b1, "R1", "iss_ready mul after reset", int'(iss_ready), 1);
        check(iss_tag == 3'd4, "R1", "iss_tag mul after reset", int'(iss_tag), 4);
        iss_op = 2'd0;
        #1;
        check(iss_tag == 3'd1, "R1", "iss_tag add after reset", int'(iss_tag), 1);

        ptr = 0; waited = 0; done_cnt = 0; cyc = 0;
        while (!(ptr == np && done_cnt == need)) begin
            int eb_add, eb_mul, ebt, pick, is_mul, er, dA, dM;
            bit ebv;
            logic [DW-1:0] ebval;
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin
                check(1'b0, "R11", "watchdog expired", done_cnt, need);
                break;
            end
            // drive
            if (ptr < np && waited >= p_dly[ptr]) begin
                iss_valid = 1'b1;
                iss_op = 2'(p_op[ptr]);
                if (p_ja[ptr] < 0) begin iss_vj = p_jv[ptr]; iss_qj = '0; end
                else if (p_done[p_ja[ptr]]) begin iss_vj = p_res[p_ja[ptr]]; iss_qj = '0; end
                else begin iss_vj = '0; iss_qj = TW'(p_tag[p_ja[ptr]]); end
                if (p_ka[ptr] < 0) begin iss_vk = p_kv[ptr]; iss_qk = '0; end
                else if (p_done[p_ka[ptr]]) begin iss_vk = p_res[p_ka[ptr]]; iss_qk = '0; end
                else begin iss_vk = '0; iss_qk = TW'(p_tag[p_ka[ptr]]); end
            end else begin
                iss_valid = 1'b0; iss_op = 2'd0;
                iss_vj = '0; iss_vk = '0; iss_qj = '0; iss_qk = '0;
            end
            #1;
            // expected outputs this cycle
            eb_mul = (u_cnt[1] == 1) ? 1 : 0;
            eb_add = (u_cnt[0] == 1) ? 1 : 0;
            ebv = (eb_mul == 1 || eb_add == 1);
            ebt = (eb_mul == 1) ? u_tag[1] : u_tag[0];
            ebval = (eb_mul == 1) ? u_val[1] : u_val[0];
            is_mul = (iss_op == 2'd2) ? 1 : 0;
            pick = 0;
            for (int s = 1; s <= 5; s++) begin
                if (pick == 0 && m_busy[s] == 0 && ((is_mul == 1) == (s > 3))) pick = s;
            end
            er = (iss_op != 2'd3 && pick != 0) ? 1 : 0;

            check(int'(iss_ready) == er, (iss_op == 2'd3) ? "R2" : "R3",
                  "iss_ready", int'(iss_ready), er);
            if (er == 1) check(int'(iss_tag) == pick, "R2", "iss_tag", int'(iss_tag), pick);
            check(bus_valid == ebv, "R7", "bus_valid", int'(bus_valid), int'(ebv));
            if (ebv) begin
                int pi;
                pi = m_prog[ebt];
                check(int'(bus_tag) == ebt, "R10", "bus_tag", int'(bus_tag), ebt);
                check(bus_value == ebval, "R4", "bus_value vs model", int'(bus_value), int'(ebval));
                check(bus_value == gold[pi], "R9", "bus_value vs program", int'(bus_value), int'(gold[pi]));
                p_done[pi] = 1'b1;
                p_res[pi] = gold[pi];
                done_cnt++;
            end

            // model advance
            dA = 0; dM = 0;
            if (u_cnt[0] == 0)
                for (int s = 1; s <= 3; s++)
                    if (dA == 0 && m_busy[s] == 1 && m_run[s] == 0 && m_qj[s] == 0 && m_qk[s] == 0) dA = s;
            if (u_cnt[1] == 0)
                for (int s = 4; s <= 5; s++)
                    if (dM == 0 && m_busy[s] == 1 && m_run[s] == 0 && m_qj[s] == 0 && m_qk[s] == 0) dM = s;
            for (int s = 1; s <= 5; s++) begin
                if (m_busy[s] == 1 && ebv) begin
                    if (m_qj[s] == ebt) begin m_vj[s] = ebval; m_qj[s] = 0; end
                    if (m_qk[s] == ebt) begin m_vk[s] = ebval; m_qk[s] = 0; end
                end
            end
            for (int u = 0; u < 2; u++) if (u_cnt[u] > 1) u_cnt[u]--;
            if (ebv) begin
                m_busy[ebt] = 0; m_run[ebt] = 0;
                if (eb_mul == 1) u_cnt[1] = 0; else u_cnt[0] = 0;
            end
            if (dA != 0) begin
                m_run[dA] = 1; u_cnt[0] = ALAT; u_tag[0] = dA;
                u_val[0] = alu(m_op[dA], m_vj[dA], m_vk[dA]);
            end
            if (dM != 0) begin
                m_run[dM] = 1; u_cnt[1] = MLAT; u_tag[1] = dM;
                u_val[1] = alu(m_op[dM], m_vj[dM], m_vk[dM]);
            end
            if (iss_valid && er == 1) begin
                m_busy[pick] = 1; m_run[pick] = 0; m_op[pick] = int'(iss_op);
                m_prog[pick] = ptr;
                if (iss_qj != 0 && ebv && int'(iss_qj) == ebt) begin m_vj[pick] = ebval; m_qj[pick] = 0; end
                else begin m_vj[pick] = iss_vj; m_qj[pick] = int'(iss_qj); end
                if (iss_qk != 0 && ebv && int'(iss_qk) == ebt) begin m_vk[pick] = ebval; m_qk[pick] = 0; end
                else begin m_vk[pick] = iss_vk; m_qk[pick] = int'(iss_qk); end
                p_tag[ptr] = pick;
                ptr++; waited = 0;
            end else if (iss_valid && iss_op == 2'd3) begin
                ptr++; waited = 0;      // R2: dropped after one refused cycle
            end else if (!iss_valid) begin
                waited++;
            end
        end

        @(negedge clk);
        iss_valid = 1'b0;
        #1;
        check(bus_valid == 1'b0, "R11", "bus idle after drain", int'(bus_valid), 0);
        check(iss_ready == 1'b1, "R11", "stations freed after drain", int'(iss_ready), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule